// File: doc/BRIEF.md
# Multi-Target Serial Peripheral Master

This block is the transmit and receive engine of a serial peripheral interface master that serves up to four peripherals, each on its own active-low select line. A word is offered on a valid/ready input stream together with a 4-bit target field and an end-of-burst flag. The engine selects the target line, waits a programmable set-up time, shifts the word out most significant bit first while it shifts in the reply, and returns the reply on an output pulse tagged with the same target field.

Every select line has its own static settings: idle clock level, sampling phase, word length from 8 to 16 bits, clock divider, set-up delay, and a recovery delay after each word. Two per-line flags decide what happens to the line after a word. The keep flag leaves it asserted until a word flagged end-of-burst is done. The drop flag releases it straight after the last clock edge. A global guard time separates the release of a kept line from the assertion of a different one. A loopback switch feeds the engine's own serial output back into its receiver. Settings must stay constant while a transfer that uses them is in progress.

Back-pressure: `tx_ready` is high only while the engine is idle or keeping a line asserted. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. A word offered during any delay or shift waits, with its fields held steady, until `tx_ready` returns. The reply output has no ready: `rx_valid` is a one-cycle pulse that the consumer must take when it appears.

Top module: `spi_cs_master`

## Requirements
- R1: The 4-bit length code of the addressed line sets the bits per word to code+8. Codes 9 to 15 are treated as 16 bits. A word produces exactly twice that many serial clock edges.
- R2: Each serial clock half period lasts the line's divider value in system clocks, with a divider of 0 treated as 1. Between words `sclk` rests at the line's polarity bit.
- R3: Transmission is MSB first from the low N bits of `tx_data`. With the phase bit set, both ends sample on the leading edge (the edge away from the rest level) and data changes on the trailing edge. With the phase bit clear, data changes on the leading edge and is sampled on the trailing edge.
- R4: The first serial clock edge comes set-up + half-period system clocks after the select line goes low, where a set-up value of 0 counts as 1.
- R5: After the last edge of a word, `tx_ready` stays low for the line's recovery delay in system clocks (0 counts as 1), counted from the cycle `rx_valid` is high.
- R6: With the keep flag set, the line stays low after a word not flagged end-of-burst, and `tx_ready` returns high while it is held. After a flagged word, the line is released when the recovery delay ends.
- R7: With the keep flag clear and the drop flag set, the line goes high in the same cycle as `rx_valid`. With both flags clear, the line stays low through the recovery delay and is released when it ends.
- R8: The drop flag has no effect while the keep flag is set.
- R9: A word taken while a line is held, but addressed to a different line, releases the held line at once. All lines then stay high for the guard time (0 counts as 1) before the new line goes low.
- R10: `rx_valid` pulses for one cycle per word. `rx_data` carries the received bits right-aligned in the low N bits with zeros above. `rx_pcs` echoes all four bits of the word's target field. The line index is the low two bits of that field.
- R11: With `loopback` high, the receiver samples `mosi` instead of `miso`, so `rx_data` equals the low N bits of the transmitted word.
- R12: At most one select line is low at any time.
- R13: After reset all select lines are high, `tx_ready` is high, `rx_valid` is low and `sclk` rests at line 0's polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_cpol | input | 4 | Rest level of the serial clock, per line |
| cs_ncpha | input | 4 | Sample-on-leading-edge flag, per line |
| cs_hold | input | 4 | Keep line asserted between words, per line |
| cs_release | input | 4 | Drop line after each word, per line |
| cs_len | input | 16 | 4-bit length code per line, line n at bits 4n+3:4n |
| cs_div | input | 32 | 8-bit clock divider per line, line n at bits 8n+7:8n |
| cs_lead | input | 32 | 8-bit set-up delay per line |
| cs_betw | input | 32 | 8-bit recovery delay per line |
| cs_gap | input | 8 | Guard time between two different lines |
| loopback | input | 1 | Route mosi into the receiver |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Engine can take a word |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_pcs | input | 4 | Target field, low two bits pick the line |
| tx_last | input | 1 | End-of-burst flag |
| rx_valid | output | 1 | Reply word present (one cycle) |
| rx_data | output | 16 | Reply word, right-aligned |
| rx_pcs | output | 4 | Target field of the reply |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low select lines |

## Verification
Two things land on the same clock edge: the final serial clock edge, which for a trailing-edge-sampling line also captures the last reply bit, and the release of the select line when the drop flag is set. The bench sweeps both phases with drop-flag lines, so the last bit and the release arrive in one cycle. On the sample where `rx_valid` first appears, it requires the complete reply word and all select lines high. A second collision occurs when a word is taken while a line is held and the word targets another line: the release and the acceptance share an edge. The bench then counts the all-high cycles and compares the count with the guard time.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  localparam int LEN_W = 4;   // length code width
  localparam int DLY_W = 8;   // divider and delay width
  localparam int NB_W  = 5;   // bit count width (up to 16)

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_LEAD, S_SHIFT, S_BETW, S_HOLD
  } seq_st_e;

  typedef struct packed {
    logic             cpol;
    logic             ncpha;
    logic             hold;
    logic             rel;
    logic [NB_W-1:0]  nbits;
    logic [DLY_W-1:0] half;
    logic [DLY_W-1:0] lead;
    logic [DLY_W-1:0] betw;
  } cs_cfg_t;

  function automatic logic [DLY_W-1:0] at_least_one(input logic [DLY_W-1:0] v);
    return (v == '0) ? DLY_W'(1) : v;
  endfunction

  function automatic logic [NB_W-1:0] len_bits(input logic [LEN_W-1:0] code);
    return (code > LEN_W'(8)) ? NB_W'(16) : (NB_W'(code) + NB_W'(8));
  endfunction

endpackage

// File: rtl/spi_cs_cfgsel.sv
module spi_cs_cfgsel
  import spi_cs_pkg::*;
#(
  parameter int NCS = 4,
  parameter int IW  = $clog2(NCS)
) (
  input  logic [IW-1:0]        idx,
  input  logic [NCS-1:0]       cpol,
  input  logic [NCS-1:0]       ncpha,
  input  logic [NCS-1:0]       hold,
  input  logic [NCS-1:0]       rel,
  input  logic [NCS*LEN_W-1:0] len,
  input  logic [NCS*DLY_W-1:0] div,
  input  logic [NCS*DLY_W-1:0] lead,
  input  logic [NCS*DLY_W-1:0] betw,
  output cs_cfg_t              cfg
);

  cs_cfg_t tbl [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_line
    assign tbl[g] = {cpol[g], ncpha[g], hold[g], rel[g],
                     len_bits(len[g*LEN_W +: LEN_W]),
                     at_least_one(div[g*DLY_W +: DLY_W]),
                     at_least_one(lead[g*DLY_W +: DLY_W]),
                     at_least_one(betw[g*DLY_W +: DLY_W])};
  end

  assign cfg = tbl[idx];

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter
  import spi_cs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     word,
  input  logic [NB_W-1:0]  nbits,
  input  logic [DLY_W-1:0] half,
  input  logic             ncpha,
  input  logic             miso,
  output logic             tog,
  output logic             mosi,
  output logic             done,
  output logic [W-1:0]     rx_word
);

  localparam int KW = $clog2(2*W+1);

  logic             active;
  logic [DLY_W-1:0] hc;
  logic [KW-1:0]    k;
  logic [W-1:0]     tsr, rsr, rsr_nx, aligned, mask;
  logic             edge_now, cap_now;

  assign aligned  = word << (W - int'(nbits));
  assign rsr_nx   = {rsr[W-2:0], miso};
  assign edge_now = active && (hc == '0);
  // next toggle is leading when an even number of toggles is done
  assign cap_now  = ((k[0] == 1'b0) == ncpha);
  assign done     = edge_now && (k == KW'({nbits, 1'b0} - 1'b1));
  assign mask     = W'((33'd1 << nbits) - 33'd1);
  // the final edge is trailing: it samples only when ncpha is clear
  assign rx_word  = (ncpha ? rsr : rsr_nx) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hc     <= '0;
      k      <= '0;
      tog    <= 1'b0;
      tsr    <= '0;
      rsr    <= '0;
      mosi   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      hc     <= half - 1'b1;
      k      <= '0;
      tog    <= 1'b0;
      rsr    <= '0;
      if (ncpha) begin
        mosi <= aligned[W-1];
        tsr  <= aligned << 1;
      end else begin
        tsr  <= aligned;
      end
    end else if (edge_now) begin
      hc  <= half - 1'b1;
      k   <= k + 1'b1;
      tog <= ~tog;
      if (done) active <= 1'b0;
      if (cap_now) begin
        rsr <= rsr_nx;
      end else begin
        mosi <= tsr[W-1];
        tsr  <= tsr << 1;
      end
    end else if (active) begin
      hc <= hc - 1'b1;
    end
  end

  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (k < KW'({nbits, 1'b0}))); // R1
  AST_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tog); // R2

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [IW-1:0]    tx_sel,
  input  logic             tx_last,
  input  cs_cfg_t          new_cfg,
  input  cs_cfg_t          cur_cfg,
  input  logic [DLY_W-1:0] gap_dly,
  input  logic             sh_done,
  output logic             tx_ready,
  output logic [IW-1:0]    cur,
  output logic             cs_on,
  output logic             sh_start
);

  seq_st_e          st;
  logic [DLY_W-1:0] cnt;
  logic             last_q;
  logic             take;

  assign tx_ready = (st == S_IDLE) || (st == S_HOLD);
  assign take     = tx_valid && tx_ready;
  assign sh_start = (st == S_LEAD) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      cur    <= '0;
      cs_on  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (take) begin
          cur    <= tx_sel;
          last_q <= tx_last;
          cs_on  <= 1'b1;
          cnt    <= new_cfg.lead - 1'b1;
          st     <= S_LEAD;
        end
        S_HOLD: if (take) begin
          cur    <= tx_sel;
          last_q <= tx_last;
          if (tx_sel == cur) begin
            cnt <= new_cfg.lead - 1'b1;
            st  <= S_LEAD;
          end else begin
            cs_on <= 1'b0;
            cnt   <= at_least_one(gap_dly) - 1'b1;
            st    <= S_GAP;
          end
        end
        S_GAP: if (cnt == '0) begin
          cs_on <= 1'b1;
          cnt   <= cur_cfg.lead - 1'b1;
          st    <= S_LEAD;
        end else cnt <= cnt - 1'b1;
        S_LEAD: if (cnt == '0) st <= S_SHIFT;
                else cnt <= cnt - 1'b1;
        S_SHIFT: if (sh_done) begin
          cnt <= cur_cfg.betw - 1'b1;
          st  <= S_BETW;
          if (!cur_cfg.hold && cur_cfg.rel) cs_on <= 1'b0;
        end
        S_BETW: if (cnt == '0) begin
          if (cur_cfg.hold && !last_q) st <= S_HOLD;
          else begin
            cs_on <= 1'b0;
            st    <= S_IDLE;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> !cs_on); // R9
  AST_HOLD_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> cs_on); // R6
  AST_START_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> cs_on); // R4

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int NCS    = 4,
  parameter int PCS_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCS-1:0]       cs_cpol,
  input  logic [NCS-1:0]       cs_ncpha,
  input  logic [NCS-1:0]       cs_hold,
  input  logic [NCS-1:0]       cs_release,
  input  logic [NCS*LEN_W-1:0] cs_len,
  input  logic [NCS*DLY_W-1:0] cs_div,
  input  logic [NCS*DLY_W-1:0] cs_lead,
  input  logic [NCS*DLY_W-1:0] cs_betw,
  input  logic [DLY_W-1:0]     cs_gap,
  input  logic                 loopback,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [WORD_W-1:0]    tx_data,
  input  logic [PCS_W-1:0]     tx_pcs,
  input  logic                 tx_last,
  output logic                 rx_valid,
  output logic [WORD_W-1:0]    rx_data,
  output logic [PCS_W-1:0]     rx_pcs,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NCS-1:0]       cs_n
);

  localparam int IW = $clog2(NCS);

  cs_cfg_t           new_cfg, cur_cfg;
  logic [IW-1:0]     tx_sel, cur;
  logic              cs_on, sh_start, sh_done, tog, rx_in, take;
  logic [WORD_W-1:0] word_q, sh_rx;
  logic [PCS_W-1:0]  tag_q;

  assign tx_sel = tx_pcs[IW-1:0];
  assign take   = tx_valid && tx_ready;
  assign rx_in  = loopback ? mosi : miso;
  assign sclk   = cur_cfg.cpol ^ tog;

  spi_cs_cfgsel #(.NCS(NCS), .IW(IW)) u_cfg_new (
    .idx(tx_sel), .cpol(cs_cpol), .ncpha(cs_ncpha), .hold(cs_hold),
    .rel(cs_release), .len(cs_len), .div(cs_div), .lead(cs_lead),
    .betw(cs_betw), .cfg(new_cfg));

  spi_cs_cfgsel #(.NCS(NCS), .IW(IW)) u_cfg_cur (
    .idx(cur), .cpol(cs_cpol), .ncpha(cs_ncpha), .hold(cs_hold),
    .rel(cs_release), .len(cs_len), .div(cs_div), .lead(cs_lead),
    .betw(cs_betw), .cfg(cur_cfg));

  spi_cs_seq #(.IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sel(tx_sel),
    .tx_last(tx_last), .new_cfg(new_cfg), .cur_cfg(cur_cfg),
    .gap_dly(cs_gap), .sh_done(sh_done), .tx_ready(tx_ready),
    .cur(cur), .cs_on(cs_on), .sh_start(sh_start));

  spi_cs_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .word(word_q),
    .nbits(cur_cfg.nbits), .half(cur_cfg.half), .ncpha(cur_cfg.ncpha),
    .miso(rx_in), .tog(tog), .mosi(mosi), .done(sh_done), .rx_word(sh_rx));

  for (genvar g = 0; g < NCS; g++) begin : g_csn
    assign cs_n[g] = !(cs_on && (cur == IW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      tag_q    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_pcs   <= '0;
    end else begin
      if (take) begin
        word_q <= tx_data;
        tag_q  <= tx_pcs;
      end
      rx_valid <= sh_done;
      if (sh_done) begin
        rx_data <= sh_rx;
        rx_pcs  <= tag_q;
      end
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R12
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10

endmodule

// File: tb/sim_spi_cs_master.sv
module sim_spi_cs_master;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [3:0] b_cpol = '0, b_ncpha = '0, b_hold = '0, b_rel = '0;
  logic [3:0] b_len [4];
  logic [7:0] b_div [4], b_lead [4], b_betw [4];
  logic [7:0] gap = '0;
  logic       lpb = 1'b0;
  logic       tx_valid = 1'b0, tx_last = 1'b0, miso = 1'b0;
  logic [15:0] tx_data = '0;
  logic [3:0]  tx_pcs = '0;
  logic        tx_ready, rx_valid, sclk, mosi;
  logic [15:0] rx_data;
  logic [3:0]  rx_pcs, cs_n;

  int total = 0;
  int bad = 0;

  spi_cs_master u0 (
    .clk(clk), .rst_n(rst_n), .cs_cpol(b_cpol), .cs_ncpha(b_ncpha),
    .cs_hold(b_hold), .cs_release(b_rel),
    .cs_len({b_len[3], b_len[2], b_len[1], b_len[0]}),
    .cs_div({b_div[3], b_div[2], b_div[1], b_div[0]}),
    .cs_lead({b_lead[3], b_lead[2], b_lead[1], b_lead[0]}),
    .cs_betw({b_betw[3], b_betw[2], b_betw[1], b_betw[0]}),
    .cs_gap(gap), .loopback(lpb), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_pcs(tx_pcs), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pcs(rx_pcs),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  // one word to line cs; creq names the requirement behind the line state after it
  task automatic xfer(input int cs, input logic [15:0] d, input logic lst,
                      input logic [15:0] s, input bit exp_gap,
                      input logic [1:0] hi, input string creq);
    int nb, hf, dl, bt, edges, capn, lead, gapc, since, hbad, cnt, csbad;
    logic [15:0] msk, mb;
    logic [3:0] own;
    logic prev, lead_edge;
    bit keep, relnow;
    nb     = (b_len[cs] > 4'd8) ? 16 : int'(b_len[cs]) + 8;
    hf     = eff(b_div[cs]);
    dl     = eff(b_lead[cs]);
    bt     = eff(b_betw[cs]);
    msk    = 16'((32'd1 << nb) - 32'd1);
    keep   = b_hold[cs] && !lst;
    relnow = !b_hold[cs] && b_rel[cs];
    own    = ~(4'b1 << cs);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    miso     = s[nb-1];
    tx_valid = 1'b1;
    tx_data  = d;
    tx_pcs   = {hi, 2'(cs)};
    tx_last  = lst;
    @(negedge clk);
    tx_valid = 1'b0;
    edges = 0; capn = 0; lead = 0; gapc = 0; since = 0; hbad = 0; mb = '0;
    prev = b_cpol[cs];
    forever begin
      since++;
      if (sclk != prev) begin
        edges++;
        if (edges > 1 && since != hf) hbad++;
        since = 0;
        prev = sclk;
        lead_edge = (sclk != b_cpol[cs]);
        if (lead_edge == b_ncpha[cs]) begin
          mb = {mb[14:0], mosi};
          capn++;
          if (capn < nb) miso = s[nb-1-capn];
        end
      end else if (edges == 0) begin
        if (cs_n == own) lead++;
        else if (cs_n == 4'hF) gapc++;
      end
      if (rx_valid) break;
      @(negedge clk);
    end
    chk("R1 edge count", edges, 2*nb);
    chk("R2 half period", hbad, 0);
    chk("R3 mosi bits", int'(mb & msk), int'(d & msk));
    chk("R4 setup time", lead, dl + hf);
    chk("R9 guard time", gapc, exp_gap ? eff(gap) : 0);
    if (lpb) chk("R11 loopback word", int'(rx_data), int'(d & msk));
    else     chk("R10 reply word", int'(rx_data), int'(s & msk));
    chk("R10 reply tag", int'(rx_pcs), int'({hi, 2'(cs)}));
    chk("R2 rest level", int'(sclk), int'(b_cpol[cs]));
    chk("R7 line at last edge", int'(cs_n), relnow ? 15 : int'(own));
    cnt = 0; csbad = 0;
    @(negedge clk);
    while (!tx_ready) begin
      cnt++;
      if (cs_n != (relnow ? 4'hF : own)) csbad++;
      @(negedge clk);
    end
    cnt++;
    chk("R5 recovery delay", cnt, bt);
    chk("R7 line during recovery", csbad, 0);
    chk(creq, int'(cs_n), keep ? int'(own) : 15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R12 watchdog act=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      b_len[i] = '0; b_div[i] = '0; b_lead[i] = '0; b_betw[i] = '0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 lines idle", int'(cs_n), 15);
    chk("R13 ready", int'(tx_ready), 1);
    chk("R13 no reply", int'(rx_valid), 0);
    chk("R13 rest level", int'(sclk), int'(b_cpol[0]));

    // sweep of lines, modes, lengths, dividers and delays (R1..R5, R7, R10)
    for (int m = 0; m < 16; m++) begin
      int cs;
      cs = m & 3;
      b_cpol[cs]  = m[2];
      b_ncpha[cs] = m[3];
      b_hold[cs]  = 1'b0;
      b_rel[cs]   = m[1];
      b_len[cs]   = 4'((m * 5) % 10);
      b_div[cs]   = 8'(m % 4);
      b_lead[cs]  = 8'((m % 3) * 2);
      b_betw[cs]  = 8'(m % 5);
      xfer(cs, 16'((m + 1) * 16'h9E37), 1'b0, 16'hC3A5 ^ 16'(m * 16'h1111),
           1'b0, 2'(m >> 2), "R7 line after recovery");
    end

    // R6 and R8: keep flag with drop flag set, burst of three words
    b_hold[2] = 1'b1; b_rel[2] = 1'b1; b_len[2] = 4'd3; b_div[2] = 8'd2;
    b_lead[2] = 8'd1; b_betw[2] = 8'd2;
    xfer(2, 16'h05A1, 1'b0, 16'h0333, 1'b0, 2'd1, "R8 drop ignored under keep");
    xfer(2, 16'h07F0, 1'b0, 16'h0123, 1'b0, 2'd1, "R6 line kept");
    xfer(2, 16'h0655, 1'b1, 16'h0777, 1'b0, 2'd1, "R6 release after last");

    // R9: held line then a different target, guard 5 then guard 0
    b_hold[1] = 1'b1; b_rel[1] = 1'b0; b_cpol[1] = 1'b1; b_ncpha[1] = 1'b0;
    b_hold[3] = 1'b0; b_rel[3] = 1'b0; b_cpol[3] = 1'b0; b_ncpha[3] = 1'b1;
    gap = 8'd5;
    xfer(1, 16'h3C3C, 1'b0, 16'hA0A0, 1'b0, 2'd0, "R6 line kept");
    xfer(3, 16'h5AA5, 1'b1, 16'h1E1E, 1'b1, 2'd3, "R9 new line released");
    gap = 8'd0;
    xfer(1, 16'h0F0F, 1'b0, 16'h7171, 1'b0, 2'd2, "R6 line kept");
    xfer(0, 16'hBEEF, 1'b1, 16'h4242, 1'b1, 2'd0, "R9 new line released");

    // R11: loopback ignores miso
    lpb = 1'b1;
    b_len[0] = 4'd8; b_ncpha[0] = 1'b0; b_rel[0] = 1'b1; b_hold[0] = 1'b0;
    xfer(0, 16'hD00D, 1'b0, 16'h2BAD, 1'b0, 2'd1, "R7 line after recovery");
    b_ncpha[0] = 1'b1;
    xfer(0, 16'h1234, 1'b0, 16'hFFFF, 1'b0, 2'd2, "R7 line after recovery");
    lpb = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule